// File: doc/BRIEF.md
# Gaussian Noise Generator

The block produces a stream of signed pseudo-random samples whose distribution is close to a normal curve. Four independent uniform sources run in parallel. Each is a 16-bit maximal-length shift register with its own feedback polynomial and start value. The upper bits of every source are added together. By the central limit theorem, the sum of several flat variables tends toward a bell shape. The sum is centred on zero, multiplied by a signed spread control, shifted right, offset by a signed centre value, and clipped to the output width.

A consumer raises `enable_i` whenever it wants samples. Each clock edge with enable high yields one new sample together with a single-cycle `valid_o`. With enable low the whole generator freezes. Typical uses are noise injection in a channel model or dithering. The spread and centre inputs let one instance serve several signal-to-noise settings without reseeding.

Top module: `gauss_noise_gen`

## Requirements
- R1: After reset, `sample_o` is 0 and `valid_o` is 0, and every source holds its fixed seed: 0xACE1, 0x1D2C, 0x7F31, 0x5A96 for sources 0 to 3.
- R2: Each source shifts left by one bit per enabled edge and inserts the XOR of its tap bits at bit 0. The tap masks are 0xD008, 0xB400, 0x8805 and 0x8016 for sources 0 to 3. A build-time option inverts the feedback (XNOR).
- R3: A source never holds its lock-up value: all zeros with XOR feedback, all ones with XNOR feedback. Its state changes on every enabled edge.
- R4: The raw sum is the sum of the top 8 bits of each source, read as unsigned. The centred value is that sum minus 512 (4 x 128).
- R5: On an enabled edge, `sample_o` becomes sat16(((centred x var_scale_i) >>> 4) + mean_i). All values are signed, `>>>` is an arithmetic shift, and the value is computed from the source states before that edge's step.
- R6: Results above 32767 are clipped to 32767. Results below -32768 are clipped to -32768.
- R7: While `enable_i` is low, the sources and `sample_o` keep their values and `valid_o` is 0. Changes on `mean_i` and `var_scale_i` during that time have no effect.
- R8: `valid_o` is 1 in exactly the cycle after each edge at which `enable_i` was high. The first sample therefore appears one cycle after enable rises.
- R9: With `var_scale_i` equal to 0, the sample equals `mean_i` exactly.
- R10: Over 10,000 samples with `mean_i` = 100 and `var_scale_i` = 16, the average lies within 8 of 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Advance the sources and produce one sample per edge |
| mean_i | input | 16 | Signed centre offset added to every sample |
| var_scale_i | input | 16 | Signed multiplier on the centred sum; controls the spread |
| sample_o | output | 16 | Signed saturated noise sample |
| valid_o | output | 1 | High for one cycle per new sample |

## Verification
The bench keeps a cycle-accurate arithmetic model of all four sources and compares every sample bit for bit. This catches a wrong tap mask, a wrong seed, an off-by-one in the bit slice, or a logical shift used where an arithmetic one belongs; any of these breaks the sequence within a few samples. Disabled stretches are interleaved with changes on the centre and spread inputs. A design that keeps stepping, or that samples the controls while frozen, drifts away from the model after enable returns. Sweeps with extreme centre and spread values must hit both clip limits: wrapping saturation would give wrong-signed outputs. A zero spread must return the centre value unchanged. A long run checks that a centring constant off by a power of two does not bias the average.

// File: rtl/gng_pkg.sv
package gng_pkg;

  localparam int SRC_W   = 16;
  localparam int MAX_SRC = 4;

  // Feedback masks: bit i set means state bit i joins the feedback XOR.
  function automatic logic [SRC_W-1:0] tap_mask(input int idx);
    case (idx)
      0:       tap_mask = 16'hD008;
      1:       tap_mask = 16'hB400;
      2:       tap_mask = 16'h8805;
      default: tap_mask = 16'h8016;
    endcase
  endfunction

  function automatic logic [SRC_W-1:0] seed_val(input int idx);
    case (idx)
      0:       seed_val = 16'hACE1;
      1:       seed_val = 16'h1D2C;
      2:       seed_val = 16'h7F31;
      default: seed_val = 16'h5A96;
    endcase
  endfunction

endpackage

// File: rtl/gng_rst_sync.sv
module gng_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/gng_lfsr.sv
module gng_lfsr #(
  parameter int              W       = 16,
  parameter logic [W-1:0]    TAPS    = '1,
  parameter logic [W-1:0]    SEED    = 1,
  parameter bit              XNOR_FB = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q, state_d;
  logic         fb_bit;

  always_comb begin
    fb_bit  = (^(state_q & TAPS)) ^ XNOR_FB;
    state_d = state_q;
    if (step_i) state_d = {state_q[W-2:0], fb_bit};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/gng_sum.sv
module gng_sum #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 16,
  parameter int TAKE_W  = 8,
  localparam int SUM_W  = TAKE_W + $clog2(NUM_SRC),
  localparam int CTR_W  = SUM_W + 1
) (
  input  logic [NUM_SRC*SRC_W-1:0] states_i,
  output logic signed [CTR_W-1:0]  centred_o
);

  localparam logic signed [CTR_W-1:0] OFFSET = CTR_W'(NUM_SRC * (1 << (TAKE_W-1)));

  logic [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      acc = acc + SUM_W'(states_i[k*SRC_W + SRC_W - TAKE_W +: TAKE_W]);
    end
    centred_o = $signed({1'b0, acc}) - OFFSET;
  end

endmodule

// File: rtl/gng_scale.sv
module gng_scale #(
  parameter int CTR_W = 11,
  parameter int OUT_W = 16,
  parameter int SHIFT = 4,
  localparam int P_W  = CTR_W + OUT_W,
  localparam int A_W  = P_W + 1
) (
  input  logic signed [CTR_W-1:0] centred_i,
  input  logic signed [OUT_W-1:0] scale_i,
  input  logic signed [OUT_W-1:0] offset_i,
  output logic        [OUT_W-1:0] result_o
);

  localparam logic signed [A_W-1:0] HI = $signed({{(A_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
  localparam logic signed [A_W-1:0] LO = ~HI;

  logic signed [P_W-1:0] ctr_ext, scl_ext, prod, shifted;
  logic signed [A_W-1:0] total;

  always_comb begin
    ctr_ext = $signed({{(P_W-CTR_W){centred_i[CTR_W-1]}}, centred_i});
    scl_ext = $signed({{(P_W-OUT_W){scale_i[OUT_W-1]}}, scale_i});
    prod    = ctr_ext * scl_ext;
    shifted = prod >>> SHIFT;
    total   = $signed({shifted[P_W-1], shifted})
            + $signed({{(A_W-OUT_W){offset_i[OUT_W-1]}}, offset_i});
    if (total > HI)      result_o = HI[OUT_W-1:0];
    else if (total < LO) result_o = LO[OUT_W-1:0];
    else                 result_o = total[OUT_W-1:0];
  end

endmodule

// File: rtl/gauss_noise_gen.sv
module gauss_noise_gen #(
  parameter int OUT_W   = 16,
  parameter int NUM_SRC = 4,
  parameter int TAKE_W  = 8,
  parameter int SHIFT   = 4,
  parameter bit XNOR_FB = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [OUT_W-1:0] mean_i,
  input  logic [OUT_W-1:0] var_scale_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);

  localparam int SRC_W = gng_pkg::SRC_W;
  localparam int CTR_W = TAKE_W + $clog2(NUM_SRC) + 1;

  logic                     rst_sync_n;
  logic [NUM_SRC*SRC_W-1:0] lfsr_flat;
  logic signed [CTR_W-1:0]  centred;
  logic [OUT_W-1:0]         scaled;
  logic [OUT_W-1:0]         sample_q, sample_d;
  logic                     valid_q, valid_d;

  gng_rst_sync u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    gng_lfsr #(
      .W      (SRC_W),
      .TAPS   (gng_pkg::tap_mask(k % gng_pkg::MAX_SRC)),
      .SEED   (gng_pkg::seed_val(k % gng_pkg::MAX_SRC)),
      .XNOR_FB(XNOR_FB)
    ) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .step_i (enable_i),
      .state_o(lfsr_flat[k*SRC_W +: SRC_W])
    );
  end

  gng_sum #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W),
    .TAKE_W (TAKE_W)
  ) u_sum (
    .states_i (lfsr_flat),
    .centred_o(centred)
  );

  gng_scale #(
    .CTR_W(CTR_W),
    .OUT_W(OUT_W),
    .SHIFT(SHIFT)
  ) u_scale (
    .centred_i(centred),
    .scale_i  ($signed(var_scale_i)),
    .offset_i ($signed(mean_i)),
    .result_o (scaled)
  );

  always_comb begin
    sample_d = sample_q;
    if (enable_i) sample_d = scaled;
    valid_d = enable_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      sample_q <= sample_d;
      valid_q  <= valid_d;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/gng_checker.sv
module gng_checker #(
  parameter int OUT_W   = 16,
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 16,
  parameter bit XNOR_FB = 1'b0
) (
  input logic                     clk_i,
  input logic                     rst_sync_n,
  input logic                     enable_i,
  input logic [OUT_W-1:0]         mean_i,
  input logic [OUT_W-1:0]         var_scale_i,
  input logic [OUT_W-1:0]         sample_o,
  input logic                     valid_o,
  input logic [NUM_SRC*SRC_W-1:0] lfsr_flat
);

  localparam logic [SRC_W-1:0] LOCK = XNOR_FB ? '1 : '0;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_lock
    // R3
    no_lockup_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      lfsr_flat[k*SRC_W +: SRC_W] != LOCK);

    // R3
    src_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      enable_i |=> lfsr_flat[k*SRC_W +: SRC_W] != $past(lfsr_flat[k*SRC_W +: SRC_W]));
  end

  // R7
  frozen_src_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !enable_i |=> $stable(lfsr_flat));

  // R7
  frozen_out_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !enable_i |=> ($stable(sample_o) && !valid_o));

  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    enable_i |=> valid_o);

  // R9
  zero_spread_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (enable_i && var_scale_i == '0) |=> sample_o == $past(mean_i));

endmodule

bind gauss_noise_gen gng_checker #(
  .OUT_W  (OUT_W),
  .NUM_SRC(NUM_SRC),
  .SRC_W  (gng_pkg::SRC_W),
  .XNOR_FB(XNOR_FB)
) i_gng_checker (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .enable_i   (enable_i),
  .mean_i     (mean_i),
  .var_scale_i(var_scale_i),
  .sample_o   (sample_o),
  .valid_o    (valid_o),
  .lfsr_flat  (lfsr_flat)
);

// File: tb/test_gauss_noise_gen.sv
module test_gauss_noise_gen;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        enable;
  logic [15:0] mean;
  logic [15:0] vscale;
  logic [15:0] sample_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] st   [4];
  logic [15:0] taps [4];
  logic [15:0] exp_sample;

  gauss_noise_gen i_gauss_noise_gen (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .enable_i   (enable),
    .mean_i     (mean),
    .var_scale_i(vscale),
    .sample_o   (sample_o),
    .valid_o    (valid_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R4, R5, R6: arithmetic model of the output
  function automatic logic [15:0] model_out(input logic [15:0] m, input logic [15:0] v);
    int sum, c, p, t;
    sum = 0;
    for (int k = 0; k < 4; k++) sum += int'(st[k][15:8]);
    c = sum - 512;
    p = c * int'($signed(v));
    t = (p >>> 4) + int'($signed(m));
    if (t > 32767)  t = 32767;
    if (t < -32768) t = -32768;
    return 16'(t);
  endfunction

  // R2: left shift, XOR of tapped bits into bit 0
  task automatic model_step();
    for (int k = 0; k < 4; k++) st[k] = {st[k][14:0], ^(st[k] & taps[k])};
  endtask

  // one clock: drive at negedge, edge, compare at next negedge
  task automatic cycle(input bit en, input logic [15:0] m, input logic [15:0] v, input string req);
    enable = en; mean = m; vscale = v;
    @(posedge clk);
    if (en) begin
      exp_sample = model_out(m, v);
      model_step();
    end
    @(negedge clk);
    check(sample_o === exp_sample, req, int'($signed(sample_o)), int'($signed(exp_sample)));
    check(valid_o === en, "R8 valid", int'(valid_o), int'(en));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi_hits, lo_hits;
    longint acc;
    taps[0] = 16'hD008; taps[1] = 16'hB400; taps[2] = 16'h8805; taps[3] = 16'h8016;
    st[0] = 16'hACE1; st[1] = 16'h1D2C; st[2] = 16'h7F31; st[3] = 16'h5A96; // R1 seeds
    exp_sample = 16'h0;
    enable = 1'b0; mean = '0; vscale = '0;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sample_o === 16'h0, "R1 sample", int'(sample_o), 0);
    check(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);

    // R8 first sample right after enable rises; R1 seeds define it
    cycle(1'b1, 16'd0, 16'd16, "R1 first sample");

    // R5 sweep of spread and centre values, bit-exact
    for (int vi = 0; vi < 8; vi++) begin
      for (int mi = 0; mi < 6; mi++) begin
        logic [15:0] vv, mm;
        vv = 16'($signed(-40 + vi * 13) * 7);
        mm = 16'(-3000 + mi * 1234);
        for (int n = 0; n < 20; n++) cycle(1'b1, mm, vv, "R5 sweep");
      end
    end

    // R9 zero spread
    for (int n = 0; n < 30; n++) cycle(1'b1, 16'(n * 997 - 15000), 16'h0, "R9 zero spread");

    // R6 clip at both limits
    hi_hits = 0; lo_hits = 0;
    for (int n = 0; n < 400; n++) begin
      cycle(1'b1, 16'h0, 16'h7FFF, "R6 saturation");
      if (sample_o == 16'h7FFF) hi_hits++;
      if (sample_o == 16'h8000) lo_hits++;
    end
    check(hi_hits > 0, "R6 upper clip reached", hi_hits, 1);
    check(lo_hits > 0, "R6 lower clip reached", lo_hits, 1);
    for (int n = 0; n < 50; n++) cycle(1'b1, 16'sh7F00, 16'sh8000, "R6 mixed clip");

    // R7 freeze: controls change while disabled, then resume matches model
    for (int r = 0; r < 5; r++) begin
      for (int n = 0; n < 7; n++) cycle(1'b0, 16'(n * 4111), 16'(n * 333 + 1), "R7 hold");
      for (int n = 0; n < 5; n++) cycle(1'b1, 16'd50, 16'd9, "R7 resume");
    end

    // R10 long-run average
    acc = 0;
    for (int n = 0; n < 10000; n++) begin
      cycle(1'b1, 16'd100, 16'd16, "R10 stream");
      acc += longint'($signed(sample_o));
    end
    check((acc / 10000) >= 92 && (acc / 10000) <= 108, "R10 average",
          int'(acc / 10000), 100);

    cycle(1'b0, 16'd0, 16'd0, "R7 final hold");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule